// File: doc/BRIEF.md
# Register-Amount Shifter with Carry-Out

This block shifts or rotates a 32-bit operand by an amount taken from the low byte of a 32-bit register word. It also produces the carry flag that the shift leaves behind. Four shift kinds are selected by a 2-bit code: logical left, logical right, arithmetic right and rotate right. The carry follows the register-amount rules for large amounts. A zero amount keeps the incoming carry. Logical shifts by exactly the width expose the last bit shifted out, and logical shifts beyond the width clear it. Arithmetic shifts of the width or more fill the result with the sign bit. Rotates reduce the amount to five bits, but they still report bit 31 as the carry for nonzero multiples of 32.

The datapath is combinational. When `OUT_REG` is 1 (the default), a single output register is placed after it, giving a latency of one clock. Flag storage lives elsewhere; the caller feeds the current carry in and keeps the new carry.

Top module: `reg_amount_shifter`

## Requirements
- R1: Only bits [7:0] of `amount` form the shift count. Bits [31:8] never affect `result` or `carry_out`.
- R2: A shift count of 0 returns the operand unchanged with `carry_out` equal to `carry_in`, for every value of `shift_kind`.
- R3: With `shift_kind` 2'b00 (logical left) and a count n from 1 to 31, `result` is the operand shifted left by n with zeros entering, and `carry_out` is operand bit 32-n.
- R4: With `shift_kind` 2'b00, a count of 32 gives `result` 0 and `carry_out` equal to operand bit 0. A count from 33 to 255 gives `result` 0 and `carry_out` 0.
- R5: With `shift_kind` 2'b01 (logical right) and a count n from 1 to 31, `result` is the operand shifted right by n with zeros entering, and `carry_out` is operand bit n-1.
- R6: With `shift_kind` 2'b01, a count of 32 gives `result` 0 and `carry_out` equal to operand bit 31. A count from 33 to 255 gives `result` 0 and `carry_out` 0.
- R7: With `shift_kind` 2'b10 (arithmetic right) and a count n from 1 to 31, `result` is the operand shifted right by n with copies of bit 31 entering, and `carry_out` is operand bit n-1. Any count of 32 or more gives every result bit equal to operand bit 31, and `carry_out` equal to operand bit 31.
- R8: With `shift_kind` 2'b11 (rotate right), a nonzero count whose low five bits are 0 (32, 64, ...) returns the operand unchanged with `carry_out` equal to operand bit 31.
- R9: With `shift_kind` 2'b11, let r be the low five bits of the count. When r is nonzero, `result` is the operand rotated right by r and `carry_out` is operand bit r-1.
- R10: With `OUT_REG`=1, outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, `result` and `carry_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| operand | input | 32 | Value to shift |
| amount | input | 32 | Register word supplying the shift count in bits [7:0] |
| shift_kind | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted value |
| carry_out | output | 1 | New carry flag |

## Verification
Counts are chosen at the edges where the carry source changes: 0, 1, 31, 32, 33 and 255. These separate a correct large-amount rule from one that masks the count to five bits or lets the bit index wrap around. Operands with bit 0, bit 31 or alternating patterns set make the carry reveal exactly which bit was picked. Negative and positive operands tell sign fill apart from zero fill. Rotates by 32, 64 and 40 check that the count is reduced to five bits while the carry still differs from the zero-count case. Amount words with junk in the upper bytes confirm that those bytes are ignored.

// File: rtl/reg_amount_shifter.sv
module reg_amount_shifter #(
  parameter int WIDTH   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] operand,
  input  logic [31:0]      amount,
  input  logic [1:0]       shift_kind,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int IDX_W = $clog2(WIDTH);

  logic [7:0]         cnt;
  logic [IDX_W-1:0]   rot, lsl_idx, rsh_idx, rot_idx;
  logic [2*WIDTH-1:0] dbl;
  logic [WIDTH-1:0]   nres;
  logic               nc;
  logic [23:0]        unused_hi;

  assign cnt       = amount[7:0];
  assign unused_hi = amount[31:8];
  assign rot       = cnt[IDX_W-1:0];
  assign lsl_idx   = IDX_W'(WIDTH - int'(cnt));
  assign rsh_idx   = IDX_W'(int'(cnt) - 1);
  assign rot_idx   = rot - 1'b1;
  assign dbl       = {operand, operand} >> rot;

  always_comb begin
    nres = operand;
    nc   = carry_in;
    if (cnt != 8'd0) begin
      case (shift_kind)
        2'b00: begin
          if (int'(cnt) < WIDTH) begin
            nres = operand << cnt;
            nc   = operand[lsl_idx];
          end else begin
            nres = '0;
            nc   = (int'(cnt) == WIDTH) ? operand[0] : 1'b0;
          end
        end
        2'b01: begin
          if (int'(cnt) < WIDTH) begin
            nres = operand >> cnt;
            nc   = operand[rsh_idx];
          end else begin
            nres = '0;
            nc   = (int'(cnt) == WIDTH) ? operand[WIDTH-1] : 1'b0;
          end
        end
        2'b10: begin
          if (int'(cnt) < WIDTH) begin
            nres = WIDTH'($signed(operand) >>> cnt);
            nc   = operand[rsh_idx];
          end else begin
            nres = {WIDTH{operand[WIDTH-1]}};
            nc   = operand[WIDTH-1];
          end
        end
        default: begin
          if (rot == '0) begin
            nres = operand;
            nc   = operand[WIDTH-1];
          end else begin
            nres = dbl[WIDTH-1:0];
            nc   = operand[rot_idx];
          end
        end
      endcase
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result    <= '0;
          carry_out <= 1'b0;
        end else begin
          result    <= nres;
          carry_out <= nc;
        end
      end

      AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (amount[7:0] == 8'd0) |=> (result == $past(operand) && carry_out == $past(carry_in))); // R2
      AST_LSL_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == 2'b00 && int'(amount[7:0]) > WIDTH) |=> (result == '0 && !carry_out)); // R4
      AST_LSR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == 2'b01 && int'(amount[7:0]) == WIDTH) |=> (result == '0 && carry_out == $past(operand[WIDTH-1]))); // R6
      AST_ASR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == 2'b10 && int'(amount[7:0]) >= WIDTH) |=>
        (result == {WIDTH{$past(operand[WIDTH-1])}} && carry_out == $past(operand[WIDTH-1]))); // R7
      AST_ROR_MULT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == 2'b11 && amount[7:0] != 8'd0 && amount[IDX_W-1:0] == '0) |=>
        (result == $past(operand) && carry_out == $past(operand[WIDTH-1]))); // R8
    end else begin : g_comb
      assign result    = nres;
      assign carry_out = nc;
    end
  endgenerate
endmodule

// File: tb/tb_reg_amount_shifter.sv
`timescale 1ns/1ps
module tb_reg_amount_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operand = '0;
  logic [31:0] amount = '0;
  logic [1:0]  shift_kind = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reg_amount_shifter dut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .amount(amount),
    .shift_kind(shift_kind), .carry_in(carry_in),
    .result(result), .carry_out(carry_out)
  );

  // Model: step one bit at a time; the carry is the last bit that left.
  function automatic logic [32:0] model(input logic [31:0] op, input logic [7:0] n,
                                        input logic [1:0] k, input logic ci);
    logic [31:0] v = op;
    logic c = ci;
    for (int i = 0; i < int'(n); i++) begin
      case (k)
        2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin v = {v[0], v[31:1]}; c = v[31]; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic run(input logic [31:0] op, input logic [31:0] amt, input logic [1:0] k,
                     input logic ci, input string tag);
    logic [32:0] exp;
    exp = model(op, amt[7:0], k, ci);
    @(negedge clk);
    operand = op; amount = amt; shift_kind = k; carry_in = ci;
    @(posedge clk);
    #1;
    checks++;
    if (result !== exp[31:0] || carry_out !== exp[32]) begin
      failures++;
      $display("FAIL %s: op=%h amt=%h kind=%b cin=%b got res=%h c=%b exp res=%h c=%b",
               tag, op, amt, k, ci, result, carry_out, exp[31:0], exp[32]);
    end
  endtask

  task automatic t_reset;
    operand = 32'hFFFF_FFFF; amount = 32'd3; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (result !== 32'd0 || carry_out !== 1'b0) begin
      failures++;
      $display("FAIL R10: reset got res=%h c=%b exp res=0 c=0", result, carry_out);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_zero;
    for (int k = 0; k < 4; k++) begin
      run(32'h8000_0001, 32'h0000_0000, 2'(k), 1'b1, "R2");
      run(32'h7FFF_FFFE, 32'hAB00_0100, 2'(k), 1'b0, "R2 R1");
    end
  endtask

  task automatic t_lsl;
    run(32'h8000_0000, 32'd1,   2'b00, 1'b0, "R3");
    run(32'h0000_0010, 32'd28,  2'b00, 1'b0, "R3");
    run(32'h0000_0003, 32'd31,  2'b00, 1'b0, "R3");
    run(32'h0000_0001, 32'd32,  2'b00, 1'b0, "R4");
    run(32'hFFFF_FFFE, 32'd32,  2'b00, 1'b1, "R4");
    run(32'hFFFF_FFFF, 32'd33,  2'b00, 1'b1, "R4");
    run(32'hFFFF_FFFF, 32'd255, 2'b00, 1'b1, "R4");
  endtask

  task automatic t_lsr;
    run(32'h0000_0001, 32'd1,  2'b01, 1'b0, "R5");
    run(32'hA5A5_5A5A, 32'd7,  2'b01, 1'b1, "R5");
    run(32'h4000_0000, 32'd31, 2'b01, 1'b0, "R5");
    run(32'h8000_0000, 32'd32, 2'b01, 1'b0, "R6");
    run(32'h7FFF_FFFF, 32'd32, 2'b01, 1'b1, "R6");
    run(32'hFFFF_FFFF, 32'd40, 2'b01, 1'b1, "R6");
  endtask

  task automatic t_asr;
    run(32'h8000_00F0, 32'd4,   2'b10, 1'b1, "R7");
    run(32'h7000_0008, 32'd4,   2'b10, 1'b0, "R7");
    run(32'hC000_0000, 32'd31,  2'b10, 1'b0, "R7");
    run(32'h8000_0000, 32'd32,  2'b10, 1'b0, "R7");
    run(32'h7FFF_FFFF, 32'd200, 2'b10, 1'b1, "R7");
  endtask

  task automatic t_ror;
    run(32'h1234_5678, 32'd32, 2'b11, 1'b0, "R8");
    run(32'h8765_4321, 32'd64, 2'b11, 1'b0, "R8");
    run(32'h0765_4321, 32'd96, 2'b11, 1'b1, "R8");
    run(32'h1234_5678, 32'd8,  2'b11, 1'b0, "R9");
    run(32'h0000_0080, 32'd40, 2'b11, 1'b0, "R9");
    run(32'h0000_0001, 32'd1,  2'b11, 1'b0, "R9");
    run(32'hFFFF_FFFE, 32'd31, 2'b11, 1'b0, "R9");
  endtask

  task automatic t_upper;
    run(32'h0F0F_00FF, 32'h1234_5604, 2'b00, 1'b0, "R1");
    run(32'h0F0F_00FF, 32'hFFFF_FF04, 2'b01, 1'b0, "R1");
    run(32'h8000_0000, 32'h0000_0120, 2'b10, 1'b0, "R1");
  endtask

  initial begin
    t_reset();
    t_zero();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_upper();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule